// File: doc/BRIEF.md
# Card slot detect and insertion monitor

This block watches the two active-low sense pins of a removable memory-card socket: the detect pin, which a seated card pulls low, and the write-protect switch pin. Both pins are brought into the clock domain through a two-stage synchronizer. The detect level is then debounced by a counter that needs a programmable number of consecutive equal samples before it declares the level settled.

From the settled level the block derives a card-inserted flag. A rising or falling edge of that flag raises a one-cycle insertion or removal interrupt pulse. If a card leaves the slot while bus power and the card clock are both on, the block also strobes two force-off outputs so that the power and clock controls can be cleared in hardware. Detection runs whether or not the bus is powered.

The software "reset all" input reaches only the write-protect path. The debounce state and the inserted flag are cleared by the hardware reset alone.

Top module: `card_slot_monitor`

## Requirements
- R1: `card_present` is the inverse of the synchronized detect pin (pin low = 1). It follows a pin change within three clock cycles.
- R2: `write_enabled` is 1 while the write-protect pin is low and 0 while it is high. It follows a pin change within four clock cycles.
- R3: `detect_stable` drops to 0 within four cycles of any change of the detect pin level. It returns to 1 only after DEBOUNCE_CYCLES consecutive equal synchronized samples. This holds for an empty slot as well as an occupied one.
- R4: `card_inserted` is 0 during reset and while debouncing. It is 1 when the level is stable and a card is present.
- R5: Each 0-to-1 change of `card_inserted` gives exactly one single-cycle `irq_insert` pulse. Each 1-to-0 change gives exactly one single-cycle `irq_remove` pulse. The two pulses never occur together.
- R6: On a removal while `bus_pwr_on` and `clk_en_on` are both 1, `force_pwr_off` and `force_clk_off` each pulse once for one cycle, in the same cycle as `irq_remove`. On a removal with either enable at 0, neither strobe pulses.
- R7: `sw_rst_all` leaves `detect_stable` and `card_inserted` unchanged and raises no interrupt. In the cycle after it is asserted, `write_enabled` reads 0. `write_enabled` recovers once the input is released.
- R8: Insertion and removal are detected and reported with `bus_pwr_on` at 0.
- R9: While `rst_n` is low, `card_present`, `card_inserted`, `detect_stable`, `write_enabled`, both interrupts and both strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Hardware reset, asynchronous assert, active low |
| sw_rst_all | input | 1 | Software reset-all request, synchronous |
| cd_n_pin | input | 1 | Raw card-detect pin, low when a card is seated |
| wp_n_pin | input | 1 | Raw write-protect pin, low when writing is allowed |
| bus_pwr_on | input | 1 | Current state of the bus power control |
| clk_en_on | input | 1 | Current state of the card clock enable |
| card_present | output | 1 | Inverse of the synchronized detect pin |
| detect_stable | output | 1 | Detect level has settled |
| card_inserted | output | 1 | Debounced card-inserted status |
| write_enabled | output | 1 | Write switch allows writing |
| irq_insert | output | 1 | One-cycle insertion interrupt pulse |
| irq_remove | output | 1 | One-cycle removal interrupt pulse |
| force_pwr_off | output | 1 | One-cycle strobe to clear bus power |
| force_clk_off | output | 1 | One-cycle strobe to clear clock enable |

## Verification
The detect pin is driven with long holds and with glitches of one to three cycles. Long holds show that a settled level gives exactly one interrupt. Glitches show that the stable flag drops at once and that the level settles again before the inserted flag recovers. Removals are repeated under every pairing of bus power and clock enable, chosen at random. This separates the one pairing that must strobe both force-off outputs from the three that must not. A software reset pulse is applied during a stable insertion, and its only visible effect must be on the write-protect path.

// File: rtl/cdm_pkg.sv
package cdm_pkg;
  localparam int unsigned CDM_SYNC_STAGES = 2;
  localparam int unsigned CDM_DEBOUNCE_DEFAULT = 1024;

  typedef struct packed {
    logic inserted;
    logic irq_ins;
    logic irq_rem;
    logic force_off;
  } slot_evt_t;
endpackage

// File: rtl/cdm_sync.sv
module cdm_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] stage_d;
    if (s == 0) begin : g_first
      assign stage_d = clr_i ? RST_VAL : d_i;
    end else begin : g_rest
      assign stage_d = clr_i ? RST_VAL : stage_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= RST_VAL;
      else         stage_q[s] <= stage_d;
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/cdm_debounce.sv
module cdm_debounce #(
  parameter int unsigned DEBOUNCE_CYCLES = 1024
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic level_i,
  output logic level_o,
  output logic stable_o
);
  localparam int unsigned CW = (DEBOUNCE_CYCLES > 1) ? $clog2(DEBOUNCE_CYCLES) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(DEBOUNCE_CYCLES - 1);

  logic          lvl_q, lvl_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          stb_q, stb_d;
  logic          cnt_en;

  assign cnt_en = (level_i == lvl_q) && (cnt_q != CNT_LAST);

  always_comb begin
    lvl_d = lvl_q;
    cnt_d = cnt_q;
    stb_d = stb_q;
    if (level_i != lvl_q) begin
      lvl_d = level_i;
      cnt_d = '0;
      stb_d = 1'b0;
    end else if (cnt_en) begin
      cnt_d = cnt_q + 1'b1;
    end else begin
      stb_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= 1'b1;
      cnt_q <= '0;
      stb_q <= 1'b0;
    end else begin
      lvl_q <= lvl_d;
      cnt_q <= cnt_d;
      stb_q <= stb_d;
    end
  end

  assign level_o  = lvl_q;
  assign stable_o = stb_q;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_ni)
    cnt_q <= CNT_LAST); // R3
  AST_CHANGE_UNSETTLES: assert property (@(posedge clk) disable iff (!rst_ni)
    (level_i != lvl_q) |=> !stable_o); // R3
endmodule

// File: rtl/cdm_slot_events.sv
module cdm_slot_events
  import cdm_pkg::*;
(
  input  logic clk,
  input  logic rst_ni,
  input  logic present_i,
  input  logic stable_i,
  input  logic pwr_i,
  input  logic clk_en_i,
  output logic inserted_o,
  output logic irq_ins_o,
  output logic irq_rem_o,
  output logic force_off_o
);
  slot_evt_t evt_q, evt_d;

  always_comb begin
    evt_d.inserted  = stable_i & present_i;
    evt_d.irq_ins   = evt_d.inserted & ~evt_q.inserted;
    evt_d.irq_rem   = ~evt_d.inserted & evt_q.inserted;
    evt_d.force_off = evt_d.irq_rem & pwr_i & clk_en_i;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) evt_q <= '0;
    else         evt_q <= evt_d;
  end

  assign inserted_o  = evt_q.inserted;
  assign irq_ins_o   = evt_q.irq_ins;
  assign irq_rem_o   = evt_q.irq_rem;
  assign force_off_o = evt_q.force_off;

  AST_IRQ_EXCL: assert property (@(posedge clk) disable iff (!rst_ni)
    !(irq_ins_o && irq_rem_o)); // R5
  AST_INS_EDGE: assert property (@(posedge clk) disable iff (!rst_ni)
    irq_ins_o |-> (inserted_o && !$past(inserted_o))); // R5
  AST_REM_EDGE: assert property (@(posedge clk) disable iff (!rst_ni)
    irq_rem_o |-> (!inserted_o && $past(inserted_o))); // R5
  AST_FORCE_GATED: assert property (@(posedge clk) disable iff (!rst_ni)
    force_off_o |-> (irq_rem_o && $past(pwr_i && clk_en_i))); // R6
  AST_INS_NEEDS_CARD: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(inserted_o) |-> $past(present_i)); // R4
endmodule

// File: rtl/card_slot_monitor.sv
module card_slot_monitor
  import cdm_pkg::*;
#(
  parameter int unsigned DEBOUNCE_CYCLES = CDM_DEBOUNCE_DEFAULT,
  parameter int unsigned SYNC_STAGES     = CDM_SYNC_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_rst_all,
  input  logic cd_n_pin,
  input  logic wp_n_pin,
  input  logic bus_pwr_on,
  input  logic clk_en_on,
  output logic card_present,
  output logic detect_stable,
  output logic card_inserted,
  output logic write_enabled,
  output logic irq_insert,
  output logic irq_remove,
  output logic force_pwr_off,
  output logic force_clk_off
);
  logic [1:0] rst_sync_q;
  logic       rst_ni;
  logic       cd_sync, wp_sync;
  logic       cd_level;
  logic       we_q, we_d;
  logic       force_off;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  cdm_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cd_sync (
    .clk(clk), .rst_ni(rst_ni), .clr_i(1'b0), .d_i(cd_n_pin), .q_o(cd_sync)
  );

  cdm_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_wp_sync (
    .clk(clk), .rst_ni(rst_ni), .clr_i(sw_rst_all), .d_i(wp_n_pin), .q_o(wp_sync)
  );

  cdm_debounce #(.DEBOUNCE_CYCLES(DEBOUNCE_CYCLES)) u_debounce (
    .clk(clk), .rst_ni(rst_ni), .level_i(cd_sync),
    .level_o(cd_level), .stable_o(detect_stable)
  );

  cdm_slot_events u_events (
    .clk(clk), .rst_ni(rst_ni),
    .present_i(~cd_level), .stable_i(detect_stable),
    .pwr_i(bus_pwr_on), .clk_en_i(clk_en_on),
    .inserted_o(card_inserted), .irq_ins_o(irq_insert),
    .irq_rem_o(irq_remove), .force_off_o(force_off)
  );

  assign we_d = sw_rst_all ? 1'b0 : ~wp_sync;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) we_q <= 1'b0;
    else         we_q <= we_d;
  end

  assign card_present  = rst_ni & ~cd_sync;
  assign write_enabled = we_q;
  assign force_pwr_off = force_off;
  assign force_clk_off = force_off;

  AST_INS_IMPLIES_PRESENT: assert property (@(posedge clk) disable iff (!rst_ni)
    card_inserted |-> $past(detect_stable)); // R4
  AST_SWRST_KEEPS_SLOT: assert property (@(posedge clk) disable iff (!rst_ni)
    (sw_rst_all && $past(sw_rst_all) && $stable(cd_sync)) |-> !irq_insert); // R7
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> (!card_inserted && !irq_insert && !irq_remove && !force_off)); // R9
endmodule

// File: tb/card_slot_monitor_tb.sv
module card_slot_monitor_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DB = 8;

  logic clk = 1'b0;
  logic rst_n, sw_rst_all, cd_n_pin, wp_n_pin, bus_pwr_on, clk_en_on;
  logic card_present, detect_stable, card_inserted, write_enabled;
  logic irq_insert, irq_remove, force_pwr_off, force_clk_off;

  int n_chk = 0, n_fail = 0;
  int c_ins = 0, c_rem = 0, c_fp = 0, c_fc = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  card_slot_monitor #(.DEBOUNCE_CYCLES(DB)) u_dut (
    .clk(clk), .rst_n(rst_n), .sw_rst_all(sw_rst_all), .cd_n_pin(cd_n_pin),
    .wp_n_pin(wp_n_pin), .bus_pwr_on(bus_pwr_on), .clk_en_on(clk_en_on),
    .card_present(card_present), .detect_stable(detect_stable),
    .card_inserted(card_inserted), .write_enabled(write_enabled),
    .irq_insert(irq_insert), .irq_remove(irq_remove),
    .force_pwr_off(force_pwr_off), .force_clk_off(force_clk_off)
  );

  always @(negedge clk) begin
    if (irq_insert)    c_ins++;
    if (irq_remove)    c_rem++;
    if (force_pwr_off) c_fp++;
    if (force_clk_off) c_fc++;
  end

  function automatic int exp_force(bit pwr, bit cen);
    return (pwr && cen) ? 1 : 0;
  endfunction

  function automatic bit exp_we(bit wp_pin);
    return !wp_pin;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic insert_remove(bit pwr, bit cen);
    int ins0, rem0, fp0, fc0;
    ins0 = c_ins; rem0 = c_rem; fp0 = c_fp; fc0 = c_fc;
    bus_pwr_on = pwr; clk_en_on = cen;
    cd_n_pin = 1'b0;
    cyc(3);
    check(card_present == 1'b1, "R1 present", card_present, 1);
    cyc(1);
    check(detect_stable == 1'b0, "R3 unsettled on insert", detect_stable, 0);
    check(card_inserted == 1'b0, "R4 inserted while debouncing", card_inserted, 0);
    cyc(DB + 10 + int'($urandom_range(0, 10)));
    check(detect_stable == 1'b1, "R3 settled full", detect_stable, 1);
    check(card_inserted == 1'b1, pwr ? "R4 inserted" : "R8 inserted unpowered", card_inserted, 1);
    check(c_ins - ins0 == 1, "R5 one insert irq", c_ins - ins0, 1);
    cd_n_pin = 1'b1;
    cyc(DB + 10 + int'($urandom_range(0, 10)));
    check(card_inserted == 1'b0, "R8 removed", card_inserted, 0);
    check(c_rem - rem0 == 1, "R5 one remove irq", c_rem - rem0, 1);
    check(c_fp - fp0 == exp_force(pwr, cen), "R6 power strobe", c_fp - fp0, exp_force(pwr, cen));
    check(c_fc - fc0 == exp_force(pwr, cen), "R6 clock strobe", c_fc - fc0, exp_force(pwr, cen));
  endtask

  initial begin
    void'($urandom(32'h5EED_0C4D));
    rst_n = 1'b0; sw_rst_all = 1'b0; cd_n_pin = 1'b1; wp_n_pin = 1'b1;
    bus_pwr_on = 1'b0; clk_en_on = 1'b0;
    cyc(3);
    check(card_present == 1'b0 && card_inserted == 1'b0 && detect_stable == 1'b0,
          "R9 reset status", {card_present, card_inserted, detect_stable}, 0);
    check(write_enabled == 1'b0 && irq_insert == 1'b0 && force_pwr_off == 1'b0,
          "R9 reset outputs", {write_enabled, irq_insert, force_pwr_off}, 0);
    rst_n = 1'b1;
    cyc(DB + 10);
    check(detect_stable == 1'b1, "R3 settled empty", detect_stable, 1);
    check(card_inserted == 1'b0, "R4 empty slot", card_inserted, 0);
    check(c_ins == 0 && c_rem == 0, "R5 no irq empty", c_ins + c_rem, 0);

    // write protect pin
    wp_n_pin = 1'b0; cyc(5);
    check(write_enabled == exp_we(1'b0), "R2 wp low", write_enabled, exp_we(1'b0));
    wp_n_pin = 1'b1; cyc(5);
    check(write_enabled == exp_we(1'b1), "R2 wp high", write_enabled, exp_we(1'b1));

    // directed removals under all enable pairings
    insert_remove(1'b1, 1'b1);
    insert_remove(1'b0, 1'b1);
    insert_remove(1'b1, 1'b0);
    insert_remove(1'b0, 1'b0);

    // glitch on the detect pin while a card is seated
    begin
      int ins0, rem0;
      bus_pwr_on = 1'b0; clk_en_on = 1'b0;
      cd_n_pin = 1'b0; cyc(DB + 12);
      ins0 = c_ins; rem0 = c_rem;
      cd_n_pin = 1'b1; cyc(2); cd_n_pin = 1'b0; cyc(2);
      check(detect_stable == 1'b0, "R3 glitch unsettles", detect_stable, 0);
      cyc(DB + 12);
      check(detect_stable == 1'b1 && card_inserted == 1'b1, "R4 recovered after glitch",
            {detect_stable, card_inserted}, 3);
      check(c_rem - rem0 == 1 && c_ins - ins0 == 1, "R5 glitch irq pair",
            (c_rem - rem0) * 10 + (c_ins - ins0), 11);
    end

    // software reset-all while seated
    begin
      int ins0, rem0;
      wp_n_pin = 1'b0; cyc(5);
      ins0 = c_ins; rem0 = c_rem;
      sw_rst_all = 1'b1; cyc(1);
      check(write_enabled == 1'b0, "R7 wp path cleared", write_enabled, 0);
      check(detect_stable == 1'b1 && card_inserted == 1'b1, "R7 slot state kept",
            {detect_stable, card_inserted}, 3);
      sw_rst_all = 1'b0; cyc(5);
      check(write_enabled == 1'b1, "R7 wp recovers", write_enabled, 1);
      check(card_inserted == 1'b1 && c_ins == ins0 && c_rem == rem0, "R7 no irq",
            (c_ins - ins0) + (c_rem - rem0), 0);
      cd_n_pin = 1'b1; cyc(DB + 12);
    end

    // random pairings
    for (int it = 0; it < 10; it++) begin
      bit wp;
      wp = 1'($urandom_range(0, 1));
      wp_n_pin = wp;
      insert_remove(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
      check(write_enabled == exp_we(wp), "R2 random wp", write_enabled, exp_we(wp));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule